// File: doc/BRIEF.md
# Per-Chain Calibration Retention Store

This block keeps the calibration results of several receive chains so that they can be saved, inspected and replayed into the radio without rerunning the calibration engines. Every chain owns a six-slot table of 28-bit words: slots 0, 1 and 2 carry the DC offset DAC settings (loop, low and high), slot 3 the filter cutoff, slot 4 the receive gain setting and slot 5 the peak detector offset.

Software reaches a chain's table through two registers of that chain: a data register that carries the word both ways, and a command register holding a slot number, a direction flag and an access flag. Software arms the command with the access flag clear, then sets the flag. The block completes the transfer and drops the flag, which software polls. A global control register switches the block on, picks the slots that take part in a replay, and holds a self-clearing replay flag. While that flag is set, the block presents the selected slots of every chain on per-chain valid/slot/word outputs, one slot per cycle in ascending order.

Top module: `radio_cal_store`

## Requirements
- R1: After reset every table slot holds 0, the enable and replay flags read 0 and the replay mask reads all ones, so the control register reads 0x000000FC.
- R2: Register map: address 0 is control (bit 0 enable, bit 1 replay flag, bits 7:2 mask where bit 2+n selects slot n). Chain c has its data register at address 1+2c (bits 27:0) and its command register at 2+2c (bits 2:0 slot, bit 3 write when 1, bit 4 access). Unused bits and addresses read 0.
- R3: A write with access set stores the data register into the addressed slot. The access flag reads 1 for two cycles after the write that set it and reads 0 from the second following clock edge.
- R4: A read with access set copies the addressed slot into the data register, visible when the access flag reads 0 with the same two-cycle latency.
- R5: Slots 6 and 7 do not exist: a write to them changes no slot, and a read returns 0 in the data register.
- R6: Chains are independent: an access on one chain leaves every other chain's table and registers unchanged.
- R7: While enable is 0, setting access or the replay flag changes no slot and produces no replay output, and the flag reads 0 after the next clock edge.
- R8: After the replay flag is set with enable 1, each mask-selected slot appears once per cycle in ascending order on every chain's valid, slot and word outputs, starting one cycle after the flag is set, with no gaps.
- R9: The replay flag reads 0 from the same clock edge that presents the last selected slot, or one edge after it is set when the mask is 0. Valid is 0 outside a replay.
- R10: A command register write while that chain's access flag is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| rs_valid | output | 3 | Replay output valid, one bit per chain |
| rs_idx | output | 9 | Replayed slot number, 3 bits per chain |
| rs_data | output | 84 | Replayed word, 28 bits per chain, 0 when not valid |

## Verification
On every cycle the assertions check the handshake timing (an access that has waited one cycle drops the flag on the next edge, a disabled block drops it at once), that a read of a missing slot leaves 0 in the data register, that a busy command register holds still, and that replay outputs come only from an active replay in strictly rising slot order. Whether the stored words are the right ones, that the chains stay apart and that each mask picks exactly its slots are shown only by the bench, which fills all tables with computed patterns, reads them back and runs a replay for every one of the 64 masks.

// File: rtl/cal_store_pkg.sv
package cal_store_pkg;
  localparam int unsigned ENTRIES = 6;
  localparam int unsigned IDX_W   = $clog2(ENTRIES + 2);

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_GO_BIT   = 1;
  localparam int unsigned CTRL_MASK_LSB = 2;

  typedef struct packed {
    logic             acc;
    logic             wr;
    logic [IDX_W-1:0] idx;
  } cmd_t;

  localparam int unsigned CMD_W = $bits(cmd_t);
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/cal_chain_tbl.sv
module cal_chain_tbl
  import cal_store_pkg::*;
#(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data_wd,
  input  logic              cmd_we,
  input  cmd_t              cmd_wd,
  input  logic [IDX_W-1:0]  rs_idx,
  output logic [WORD_W-1:0] data_q,
  output cmd_t              cmd_q,
  output logic [WORD_W-1:0] rs_word
);
  logic [WORD_W-1:0] mem_q [ENTRIES];
  logic [WORD_W-1:0] data_d;
  cmd_t              cmd_d;
  logic              stage_q, stage_d;
  logic              mem_we;
  logic              idx_ok, rs_ok;
  logic [IDX_W-1:0]  idx_safe, rs_safe;

  assign idx_ok   = cmd_q.idx < IDX_W'(ENTRIES);
  assign idx_safe = idx_ok ? cmd_q.idx : '0;
  assign rs_ok    = rs_idx < IDX_W'(ENTRIES);
  assign rs_safe  = rs_ok ? rs_idx : '0;
  assign rs_word  = rs_ok ? mem_q[rs_safe] : '0;

  always_comb begin
    data_d  = data_q;
    cmd_d   = cmd_q;
    stage_d = stage_q;
    mem_we  = 1'b0;
    if (data_we) data_d = data_wd;
    if (cmd_q.acc) begin
      if (!enable) begin
        cmd_d.acc = 1'b0;
        stage_d   = 1'b0;
      end else if (!stage_q) begin
        stage_d = 1'b1;
      end else begin
        stage_d   = 1'b0;
        cmd_d.acc = 1'b0;
        if (cmd_q.wr) mem_we = idx_ok;
        else          data_d = idx_ok ? mem_q[idx_safe] : '0;
      end
    end else if (cmd_we) begin
      cmd_d = cmd_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      cmd_q   <= '0;
      stage_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      cmd_q   <= cmd_d;
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (mem_we) begin
      mem_q[idx_safe] <= data_q;
    end
  end

  // R3
  acc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.acc && stage_q) |=> !cmd_q.acc);

  // R7
  acc_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.acc && !enable) |=> !cmd_q.acc);

  // R5
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.acc && stage_q && enable && !cmd_q.wr && !idx_ok) |=> (data_q == '0));

  // R10
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q.acc && !stage_q && enable) |=> ($stable(cmd_q.idx) && $stable(cmd_q.wr)));
endmodule

// File: rtl/cal_restore_seq.sv
module cal_restore_seq
  import cal_store_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               start,
  input  logic [ENTRIES-1:0] mask,
  output logic               busy_q,
  output logic               out_valid_q,
  output logic [IDX_W-1:0]   out_idx_q
);
  logic [ENTRIES-1:0] remain_q, remain_d, remain_clr;
  logic               busy_d, valid_d;
  logic [IDX_W-1:0]   idx_d, pick;

  always_comb begin
    pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (remain_q[i]) pick = IDX_W'(i);
    end
  end

  assign remain_clr = remain_q & (remain_q - 1'b1);

  always_comb begin
    busy_d   = busy_q;
    remain_d = remain_q;
    valid_d  = 1'b0;
    idx_d    = out_idx_q;
    if (!busy_q) begin
      if (start) begin
        busy_d   = 1'b1;
        remain_d = mask;
      end
    end else if (!enable) begin
      busy_d   = 1'b0;
      remain_d = '0;
    end else if (remain_q == '0) begin
      busy_d = 1'b0;
    end else begin
      valid_d  = 1'b1;
      idx_d    = pick;
      remain_d = remain_clr;
      if (remain_clr == '0) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      remain_q    <= '0;
      out_valid_q <= 1'b0;
      out_idx_q   <= '0;
    end else begin
      busy_q      <= busy_d;
      remain_q    <= remain_d;
      out_valid_q <= valid_d;
      out_idx_q   <= idx_d;
    end
  end

  // R8
  replay_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_q |-> $past(busy_q));

  // R8
  replay_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && $past(out_valid_q)) |-> (out_idx_q > $past(out_idx_q)));

  // R7
  replay_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_valid_q);
endmodule

// File: rtl/radio_cal_store.sv
module radio_cal_store
  import cal_store_pkg::*;
#(
  parameter int unsigned NCHAIN = 3,
  parameter int unsigned WORD_W = 28,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned REG_AW = $clog2(2 * NCHAIN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_we,
  input  logic [REG_AW-1:0]         bus_addr,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  output logic [NCHAIN-1:0]         rs_valid,
  output logic [NCHAIN*IDX_W-1:0]   rs_idx,
  output logic [NCHAIN*WORD_W-1:0]  rs_data
);
  logic               rst_sync_n;
  logic               en_q, en_d;
  logic [ENTRIES-1:0] mask_q, mask_d;
  logic               ctrl_we, start;
  logic               busy, out_valid;
  logic [IDX_W-1:0]   out_idx;
  logic               unused_hi;

  logic [WORD_W-1:0]  ch_data [NCHAIN];
  cmd_t               ch_cmd  [NCHAIN];
  logic [WORD_W-1:0]  ch_word [NCHAIN];

  assign unused_hi = ^bus_wdata[BUS_W-1:WORD_W];

  cal_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign ctrl_we = bus_we && (bus_addr == '0);
  assign start   = ctrl_we && bus_wdata[CTRL_GO_BIT];

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    if (ctrl_we) begin
      en_d   = bus_wdata[CTRL_EN_BIT];
      mask_d = bus_wdata[CTRL_MASK_LSB +: ENTRIES];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  cal_restore_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .enable      (en_q),
    .start       (start),
    .mask        (bus_wdata[CTRL_MASK_LSB +: ENTRIES]),
    .busy_q      (busy),
    .out_valid_q (out_valid),
    .out_idx_q   (out_idx)
  );

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    logic data_we, cmd_we;
    assign data_we = bus_we && (bus_addr == REG_AW'(1 + 2 * c));
    assign cmd_we  = bus_we && (bus_addr == REG_AW'(2 + 2 * c));

    cal_chain_tbl #(.WORD_W(WORD_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .enable  (en_q),
      .data_we (data_we),
      .data_wd (bus_wdata[WORD_W-1:0]),
      .cmd_we  (cmd_we),
      .cmd_wd  (cmd_t'(bus_wdata[CMD_W-1:0])),
      .rs_idx  (out_idx),
      .data_q  (ch_data[c]),
      .cmd_q   (ch_cmd[c]),
      .rs_word (ch_word[c])
    );

    assign rs_valid[c]                   = out_valid;
    assign rs_idx[c*IDX_W +: IDX_W]      = out_idx;
    assign rs_data[c*WORD_W +: WORD_W]   = out_valid ? ch_word[c] : '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      bus_rdata[CTRL_EN_BIT]                = en_q;
      bus_rdata[CTRL_GO_BIT]                = busy;
      bus_rdata[CTRL_MASK_LSB +: ENTRIES]   = mask_q;
    end
    for (int c = 0; c < NCHAIN; c++) begin
      if (bus_addr == REG_AW'(1 + 2 * c)) bus_rdata[WORD_W-1:0] = ch_data[c];
      if (bus_addr == REG_AW'(2 + 2 * c)) bus_rdata[CMD_W-1:0]  = ch_cmd[c];
    end
  end

  // R9
  replay_flag_ends_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !busy) |=> !out_valid);
endmodule

// File: tb/radio_cal_store_tb.sv
module radio_cal_store_tb;
  localparam int NCH = 3;
  localparam int NE  = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  rs_valid;
  logic [8:0]  rs_idx;
  logic [83:0] rs_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  logic [27:0] exp_tbl [NCH][NE];

  radio_cal_store u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rs_valid(rs_valid), .rs_idx(rs_idx), .rs_data(rs_data)
  );

  always #4 clk = ~clk;

  function automatic logic [27:0] pat(int c, int e, int salt);
    return 28'((c * 7 + e + 1) * 32'h0123457 + salt * 32'h0ABCDE);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tbl_write(int c, int e, logic [27:0] v, bit timed);
    logic [31:0] r;
    wr(3'(1 + 2 * c), {4'h0, v});
    wr(3'(2 + 2 * c), 32'(8 | e));
    wr(3'(2 + 2 * c), 32'(24 | e));
    if (timed) begin
      rd(3'(2 + 2 * c), r); chk("R3 access after set", r, 32'(24 | e));
      step();
      rd(3'(2 + 2 * c), r); chk("R3 access one cycle on", 32'(r[4]), 1);
      step();
      rd(3'(2 + 2 * c), r); chk("R3 access cleared", 32'(r[4]), 0);
    end else begin
      step(); step();
    end
    if (e < NE) exp_tbl[c][e] = v;
  endtask

  task automatic tbl_read(int c, int e, output logic [31:0] d);
    wr(3'(2 + 2 * c), 32'(e));
    wr(3'(2 + 2 * c), 32'(16 | e));
    step(); step();
    rd(3'(1 + 2 * c), d);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: reset values and register layout
    rd(3'd0, r); chk("R1 ctrl reset", r, 32'h0000_00FC);
    for (int c = 0; c < NCH; c++) begin
      rd(3'(1 + 2 * c), r); chk("R1 data reg reset", r, 0);
      rd(3'(2 + 2 * c), r); chk("R1 cmd reg reset", r, 0);
    end
    rd(3'd7, r); chk("R2 unused address", r, 0);
    wr(3'd0, 32'h0000_00FD);
    rd(3'd0, r); chk("R2 ctrl enable on", r, 32'h0000_00FD);
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NE; e++) begin
        tbl_read(c, e, r); chk("R1 slot reset zero", r, 0);
      end

    // R3 R5: fill every slot including missing ones
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < 8; e++)
        tbl_write(c, e, pat(c, e, 0), (e == 2));
    // R4 R5 R6: read back all
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < 8; e++) begin
        tbl_read(c, e, r);
        if (e < NE) chk("R4 readback", r, {4'h0, exp_tbl[c][e]});
        else        chk("R5 missing slot reads 0", r, 0);
      end

    // R6: rewrite one slot of chain 1, others unchanged
    tbl_write(1, 2, pat(1, 2, 5), 0);
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NE; e++) begin
        tbl_read(c, e, r); chk("R6 chain isolation", r, {4'h0, exp_tbl[c][e]});
      end

    // R10: command write ignored while busy
    wr(3'd2, 32'h0000_0001);
    wr(3'd2, 32'h0000_0011);
    wr(3'd2, 32'h0000_001C);
    step();
    rd(3'd2, r); chk("R10 cmd kept", r, 32'h0000_0001);
    rd(3'd1, r); chk("R10 read done", r, {4'h0, exp_tbl[0][1]});
    tbl_read(0, 4, r); chk("R10 slot untouched", r, {4'h0, exp_tbl[0][4]});

    // R7: disabled block
    wr(3'd0, 32'h0000_00FC);
    wr(3'd1, 32'h0FFF_FFFF);
    wr(3'd2, 32'h0000_0008);
    wr(3'd2, 32'h0000_0018);
    step();
    rd(3'd2, r); chk("R7 access self-clears", 32'(r[4]), 0);
    wr(3'd0, 32'h0000_00FE);
    chk("R7 no replay when off", 32'(rs_valid), 0);
    step();
    rd(3'd0, r); chk("R7 replay flag clears", r, 32'h0000_00FC);
    chk("R7 no replay output", 32'(rs_valid), 0);
    wr(3'd0, 32'h0000_00FD);
    tbl_read(0, 0, r); chk("R7 slot unchanged", r, {4'h0, exp_tbl[0][0]});

    // R8 R9: every mask
    for (int m = 0; m < 64; m++) begin
      int k;
      int seen;
      k = $countones(m);
      seen = 0;
      wr(3'd0, 32'((m << 2) | 3));
      chk("R9 valid low at start", 32'(rs_valid), 0);
      if (k == 0) begin
        step();
        rd(3'd0, r); chk("R9 empty mask clears", 32'(r[1]), 0);
        chk("R9 empty mask no output", 32'(rs_valid), 0);
      end
      for (int e = 0; e < NE; e++) begin
        if (m[e]) begin
          step();
          seen++;
          rd(3'd0, r);
          chk("R9 replay flag", 32'(r[1]), (seen == k) ? 0 : 1);
          chk("R8 valid", 32'(rs_valid), 32'h7);
          for (int c = 0; c < NCH; c++) begin
            chk("R8 slot", 32'(rs_idx[c*3 +: 3]), 32'(e));
            chk("R8 word", 32'(rs_data[c*28 +: 28]), {4'h0, exp_tbl[c][e]});
          end
        end
      end
      step();
      chk("R9 valid ends", 32'(rs_valid), 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule